// File: doc/BRIEF.md
# Windowed Two-State Max-Log Soft Decoder

This block is a soft-in soft-out decoder for a code whose trellis has two states. It handles the accumulator code 1/(1+D) and the differential code 1+D. It works on log-likelihood ratios (LLRs). The sign of an LLR gives the hard bit: positive means 0. The magnitude gives the confidence. Every state update reduces to one parity-combining function, g(a,b) = sign(a)·sign(b)·min(|a|,|b|), followed by a saturating add.

A block of `N_WIN × WIN_LEN` trellis stages is decoded one window at a time. For each stage of a window, the caller streams in an a-priori LLR for the information bit and a channel LLR for the coded bit. During this phase the forward metric is updated and stored. The block then runs backward over the same window and emits one extrinsic LLR per stage, from the last stage of the window down to the first. Only one window of forward metrics is held at any time. The forward metric carries straight on into the next window.

The backward recursion needs a starting value at the end of each window. That value is the backward message the previous run of the block computed at the first stage of the following window. Iterative decoding therefore gets window initialisation without training runs. On the first iteration, `first_iter` forces every such start value to zero.

Top module: `siso2_sw_dec`

## Requirements
- R1: After a synchronous active-low reset, `in_rdy`, `out_vld` and `done` are all low, and the block waits for `start`.
- R2: `in_rdy` is high only while the block is collecting a window. A stage is taken on a clock edge where `in_vld` and `in_rdy` are both high. After exactly `WIN_LEN` stages, `in_rdy` drops and `out_vld` stays high for exactly `WIN_LEN` cycles. `in_rdy` and `out_vld` are never high together, and both are low once the block ends.
- R3: `out_idx` gives the absolute stage number of `out_ext`. Within a window the stages come out one per cycle in strictly descending order. Windows come out in ascending order.
- R4: Every LLR lies in the symmetric range ±(2^(LLR_W−1)−1), which is ±127 for 8 bits. Every addition clamps to that range instead of wrapping, and the most negative code is never produced.
- R5: With `code_sel`=0 (accumulator), x=a-priori and y=channel. The forward metric is α_k = sat(g(α_{k−1}, x_k) + y_k), with α_{−1} = +127 because the start state is known to be 0. The backward metric is β_k = sat(y_k + m_k), where m_k is the message arriving from stage k+1. The output is ext_k = g(α_{k−1}, β_k).
- R6: With `code_sel`=1 (1+D), x=channel and y=a-priori, with α_{−1} = 0. The same forward and backward updates apply. The output is ext_k = sat(g(α_{k−1}, x_k) + m_k).
- R7: The forward metric is not reset between windows of a block. The first stage of window w uses the α left by the last stage of window w−1.
- R8: The message into stage k−1 is m_{k−1} = g(x_k, β_k). The last window always starts its backward run with m = 0. Every other window w starts with m = 0 when `first_iter` was 1 at `start`. Otherwise it starts with the message that the previous block computed at the first stage of window w+1.
- R9: `start` is sampled only while idle, together with `code_sel` and `first_iter`. Pulses while busy have no effect. `done` is high for one cycle, together with the last output, stage (N_WIN−1)·WIN_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a block (sampled when idle) |
| code_sel | input | 1 | 0 = accumulator 1/(1+D), 1 = differential 1+D |
| first_iter | input | 1 | 1 = zero window start messages instead of stored ones |
| in_vld | input | 1 | Stage LLR pair valid |
| in_rdy | output | 1 | Block is collecting stages |
| in_apri | input | LLR_W | Signed a-priori LLR of the information bit |
| in_chan | input | LLR_W | Signed channel LLR of the coded bit |
| out_vld | output | 1 | Extrinsic output valid |
| out_ext | output | LLR_W | Signed extrinsic LLR |
| out_idx | output | clog2(N_WIN·WIN_LEN) | Stage number of `out_ext` |
| done | output | 1 | One-cycle pulse with the final output |

## Verification
The assertions assume the caller never drives the most negative code on an LLR input. They also assume the caller takes every output in the cycle it appears, because the output side has no backpressure. The bench draws LLRs only from ±127. It samples `out_vld` on every cycle and inserts random idle cycles on `in_vld` only. It sets `first_iter`=0 only when the previous block used the same code. A deliberate `start` pulse with both mode inputs inverted, sent in the middle of a block, confirms that the mode is latched once.

// File: rtl/siso2_pkg.sv
// Package: shared phase type and LLR arithmetic for the two-state decoder.
// Assumes the caller passes a positive clamp limit; integers are wide enough
// for any sum of two LLRs of the project's widths.
package siso2_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FWD  = 2'd1,
        PH_BWD  = 2'd2
    } siso2_phase_e;

    // Clamp v into [-lim, +lim].
    function automatic int llr_sat(input int v, input int lim);
        if (v > lim)  return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    // Max-log parity combine: sign product times minimum magnitude.
    function automatic int llr_g(input int a, input int b);
        int ma;
        int mb;
        int m;
        ma = (a < 0) ? -a : a;
        mb = (b < 0) ? -b : b;
        m  = (ma < mb) ? ma : mb;
        return ((a < 0) != (b < 0)) ? -m : m;
    endfunction

endpackage

// File: rtl/siso2_ctrl.sv
// Sequencer: runs a block window by window, first collecting WIN_LEN stages
// (forward), then counting the same positions back down (backward).
// Assumes N_WIN >= 2 and WIN_LEN >= 2.
module siso2_ctrl #(
    parameter int WIN_LEN = 8,
    parameter int N_WIN   = 4,
    localparam int POS_W  = $clog2(WIN_LEN),
    localparam int WID_W  = $clog2(N_WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             code_sel,
    input  logic             first_iter,
    input  logic             in_vld,
    output logic             blk_go,
    output logic             fwd_take,
    output logic             to_bwd,
    output logic             bwd_act,
    output logic             blk_end,
    output logic             last_win,
    output logic [POS_W-1:0] pos,
    output logic [WID_W-1:0] win,
    output logic             code_r,
    output logic             first_r
);
    import siso2_pkg::*;

    siso2_phase_e phase;

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(WIN_LEN - 1);
    localparam logic [WID_W-1:0] WIN_LAST = WID_W'(N_WIN - 1);

    // Decode the current phase into strobes for the datapath.
    always_comb begin
        blk_go   = (phase == PH_IDLE) && start;
        fwd_take = (phase == PH_FWD) && in_vld;
        to_bwd   = fwd_take && (pos == POS_LAST);
        bwd_act  = (phase == PH_BWD);
        last_win = (win == WIN_LAST);
        blk_end  = bwd_act && (pos == '0) && last_win;
    end

    // Phase, position and window counters; mode latched on a start accepted while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            pos     <= '0;
            win     <= '0;
            code_r  <= 1'b0;
            first_r <= 1'b1;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase   <= PH_FWD;
                    pos     <= '0;
                    win     <= '0;
                    code_r  <= code_sel;
                    first_r <= first_iter;
                end
                PH_FWD: if (in_vld) begin
                    if (pos == POS_LAST) phase <= PH_BWD;
                    else                 pos   <= pos + POS_W'(1);
                end
                PH_BWD: begin
                    if (pos != '0) begin
                        pos <= pos - POS_W'(1);
                    end else if (last_win) begin
                        phase <= PH_IDLE;
                    end else begin
                        win   <= win + WID_W'(1);
                        phase <= PH_FWD;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/siso2_wbuf.sv
// Window store: one word per stage of the current window, written in the
// forward phase and read back at any address in the backward phase.
// Assumes a write and a read never need the same entry in one cycle.
module siso2_wbuf #(
    parameter int WORD_W = 24,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Store one stage word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Asynchronous read for the backward step.
    assign rdata = mem[raddr];

endmodule

// File: rtl/siso2_bmem.sv
// Boundary store: one backward message per window, kept across block runs so
// the next iteration can seed each window's backward recursion.
// Cleared by reset to the equiprobable value 0.
module siso2_bmem #(
    parameter int LLR_W  = 8,
    parameter int N_WIN  = 4,
    localparam int WID_W = $clog2(N_WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WID_W-1:0] waddr,
    input  logic [LLR_W-1:0] wdata,
    input  logic [WID_W-1:0] raddr,
    output logic [LLR_W-1:0] rdata
);
    logic [LLR_W-1:0] mem [N_WIN];

    // Clear on reset, else record one window message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_WIN; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Asynchronous read when a window turns to its backward run.
    assign rdata = mem[raddr];

endmodule

// File: rtl/siso2_sw_dec.sv
// Top: windowed max-log forward-backward decoder for a two-state trellis.
// Forward: alpha_k = sat(g(alpha_{k-1}, x_k) + y_k), stored per stage with x, y.
// Backward: beta_k = sat(y_k + m_k); outgoing message g(x_k, beta_k).
// Assumes LLR inputs within +/-(2^(LLR_W-1)-1) and that outputs are taken each cycle.
module siso2_sw_dec #(
    parameter int LLR_W   = 8,
    parameter int WIN_LEN = 8,
    parameter int N_WIN   = 4,
    localparam int BLK    = WIN_LEN * N_WIN,
    localparam int IDX_W  = $clog2(BLK),
    localparam int POS_W  = $clog2(WIN_LEN),
    localparam int WID_W  = $clog2(N_WIN),
    localparam int LIM    = 2 ** (LLR_W - 1) - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    code_sel,
    input  logic                    first_iter,
    input  logic                    in_vld,
    output logic                    in_rdy,
    input  logic signed [LLR_W-1:0] in_apri,
    input  logic signed [LLR_W-1:0] in_chan,
    output logic                    out_vld,
    output logic signed [LLR_W-1:0] out_ext,
    output logic        [IDX_W-1:0] out_idx,
    output logic                    done
);
    import siso2_pkg::*;

    logic             blk_go, fwd_take, to_bwd, bwd_act, blk_end, last_win;
    logic             code_r, first_r;
    logic [POS_W-1:0] pos;
    logic [WID_W-1:0] win;

    logic signed [LLR_W-1:0] alpha_r, msg_r;
    logic signed [LLR_W-1:0] x_in, y_in, alpha_nx;
    logic signed [LLR_W-1:0] ap_k, x_k, y_k, beta_k, msg_nx, ext_k;
    logic        [LLR_W-1:0] bnd_rd;
    logic      [3*LLR_W-1:0] wb_rd;

    siso2_ctrl #(.WIN_LEN(WIN_LEN), .N_WIN(N_WIN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .code_sel(code_sel),
        .first_iter(first_iter), .in_vld(in_vld), .blk_go(blk_go),
        .fwd_take(fwd_take), .to_bwd(to_bwd), .bwd_act(bwd_act),
        .blk_end(blk_end), .last_win(last_win), .pos(pos), .win(win),
        .code_r(code_r), .first_r(first_r)
    );

    // Lane mapping: the g-lane is the information bit for the accumulator, the coded bit for 1+D.
    always_comb begin
        x_in     = code_r ? in_chan : in_apri;
        y_in     = code_r ? in_apri : in_chan;
        alpha_nx = LLR_W'(llr_sat(llr_g(int'(alpha_r), int'(x_in)) + int'(y_in), LIM));
    end

    siso2_wbuf #(.WORD_W(3 * LLR_W), .DEPTH(WIN_LEN)) u_wbuf (
        .clk(clk), .we(fwd_take), .waddr(pos), .wdata({alpha_r, x_in, y_in}),
        .raddr(pos), .rdata(wb_rd)
    );

    // Backward step on the stored stage: new beta, outgoing message, extrinsic.
    always_comb begin
        {ap_k, x_k, y_k} = wb_rd;
        beta_k = LLR_W'(llr_sat(int'(y_k) + int'(msg_r), LIM));
        msg_nx = LLR_W'(llr_g(int'(x_k), int'(beta_k)));
        if (code_r) ext_k = LLR_W'(llr_sat(llr_g(int'(ap_k), int'(x_k)) + int'(msg_r), LIM));
        else        ext_k = LLR_W'(llr_g(int'(ap_k), int'(beta_k)));
    end

    siso2_bmem #(.LLR_W(LLR_W), .N_WIN(N_WIN)) u_bmem (
        .clk(clk), .rst_n(rst_n),
        .we(bwd_act && (pos == '0) && (win != '0)),
        .waddr(win - WID_W'(1)), .wdata(msg_nx),
        .raddr(win), .rdata(bnd_rd)
    );

    // Forward metric: seeded at block start, advanced per accepted stage, kept across windows.
    always_ff @(posedge clk) begin
        if (!rst_n)        alpha_r <= '0;
        else if (blk_go)   alpha_r <= code_sel ? LLR_W'(0) : LLR_W'(LIM);
        else if (fwd_take) alpha_r <= alpha_nx;
    end

    // Backward message: seeded when a window turns, advanced per backward step.
    always_ff @(posedge clk) begin
        if (!rst_n)       msg_r <= '0;
        else if (to_bwd)  msg_r <= (last_win || first_r) ? LLR_W'(0) : bnd_rd;
        else if (bwd_act) msg_r <= msg_nx;
    end

    // Port outputs follow the phase directly.
    always_comb begin
        in_rdy  = fwd_take || (!bwd_act && !blk_go && u_ctrl.phase == siso2_pkg::PH_FWD);
        out_vld = bwd_act;
        out_ext = ext_k;
        out_idx = IDX_W'(int'(win) * WIN_LEN + int'(pos));
        done    = blk_end;
    end

endmodule

// File: rtl/siso2_chk.sv
// Checker: port-level protocol and range properties of siso2_sw_dec, bound below.
// Assumes the caller never drives the most negative LLR code.
module siso2_chk #(
    parameter int LLR_W   = 8,
    parameter int WIN_LEN = 8,
    parameter int N_WIN   = 4,
    localparam int IDX_W  = $clog2(WIN_LEN * N_WIN)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_rdy,
    input logic                    out_vld,
    input logic signed [LLR_W-1:0] out_ext,
    input logic        [IDX_W-1:0] out_idx,
    input logic                    done
);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'((N_WIN - 1) * WIN_LEN);
    localparam logic [LLR_W-1:0] NEG_FULL = {1'b1, {(LLR_W - 1){1'b0}}};

    // R2: collecting and emitting never overlap.
    a_r2_rdy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        in_rdy |-> !out_vld);

    // R3: consecutive outputs step down by one stage.
    a_r3_idx_desc: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(out_vld)) |-> (out_idx == $past(out_idx) - IDX_W'(1)));

    // R4: the clamp never yields the most negative code.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_ext != NEG_FULL));

    // R9: done marks the final stage of the block.
    a_r9_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_vld && out_idx == IDX_END));

    // R9: done lasts a single cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind siso2_sw_dec siso2_chk #(.LLR_W(LLR_W), .WIN_LEN(WIN_LEN), .N_WIN(N_WIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_rdy(in_rdy), .out_vld(out_vld),
    .out_ext(out_ext), .out_idx(out_idx), .done(done)
);

// File: tb/sim_siso2_sw_dec.sv
// Bench: random and directed blocks, each compared against a model built from the requirements.
module sim_siso2_sw_dec;
    localparam int LLR_W   = 8;
    localparam int WIN_LEN = 8;
    localparam int N_WIN   = 4;
    localparam int BLK     = WIN_LEN * N_WIN;
    localparam int IDX_W   = $clog2(BLK);
    localparam int LIM     = 127;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start = 1'b0;
    logic                    code_sel = 1'b0;
    logic                    first_iter = 1'b1;
    logic                    in_vld = 1'b0;
    logic                    in_rdy;
    logic signed [LLR_W-1:0] in_apri = '0;
    logic signed [LLR_W-1:0] in_chan = '0;
    logic                    out_vld;
    logic signed [LLR_W-1:0] out_ext;
    logic        [IDX_W-1:0] out_idx;
    logic                    done;

    int n_tests = 0;
    int n_fail  = 0;
    int av [BLK];
    int pv [BLK];
    int bnd_old [N_WIN];
    int exp_ext [BLK];
    int exp_idx [BLK];

    always #10 clk = ~clk;

    siso2_sw_dec #(.LLR_W(LLR_W), .WIN_LEN(WIN_LEN), .N_WIN(N_WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .code_sel(code_sel),
        .first_iter(first_iter), .in_vld(in_vld), .in_rdy(in_rdy),
        .in_apri(in_apri), .in_chan(in_chan), .out_vld(out_vld),
        .out_ext(out_ext), .out_idx(out_idx), .done(done)
    );

    function automatic int sat(input int v);
        return (v > LIM) ? LIM : ((v < -LIM) ? -LIM : v);
    endfunction

    function automatic int gc(input int a, input int b);
        int ma = (a < 0) ? -a : a;
        int mb = (b < 0) ? -b : b;
        int m = (ma < mb) ? ma : mb;
        return ((a < 0) != (b < 0)) ? -m : m;
    endfunction

    task automatic check(input string req, input string what, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Expected outputs in emission order (R3, R5, R6, R7, R8).
    task automatic build_expect(input int code, input int first);
        int ap [BLK];
        int bnd_new [N_WIN];
        int prev;
        prev = (code == 0) ? LIM : 0;
        for (int k = 0; k < BLK; k++) begin
            int x = (code == 0) ? av[k] : pv[k];
            int y = (code == 0) ? pv[k] : av[k];
            ap[k] = prev;
            prev = sat(gc(prev, x) + y);
        end
        bnd_new = bnd_old;
        for (int w = 0; w < N_WIN; w++) begin
            int m = (w == N_WIN - 1 || first != 0) ? 0 : bnd_old[w];
            for (int j = WIN_LEN - 1; j >= 0; j--) begin
                int k = w * WIN_LEN + j;
                int e = w * WIN_LEN + (WIN_LEN - 1 - j);
                int x = (code == 0) ? av[k] : pv[k];
                int y = (code == 0) ? pv[k] : av[k];
                int b = sat(y + m);
                exp_ext[e] = (code == 0) ? gc(ap[k], b) : sat(gc(ap[k], x) + m);
                exp_idx[e] = k;
                m = gc(x, b);
                if (j == 0 && w > 0) bnd_new[w - 1] = m;
            end
        end
        bnd_old = bnd_new;
    endtask

    task automatic fill(input int mode);
        for (int k = 0; k < BLK; k++) begin
            case (mode)
                0: begin av[k] = $urandom_range(0, 254) - 127; pv[k] = $urandom_range(0, 254) - 127; end
                1: begin av[k] = $urandom_range(0, 20) - 10;   pv[k] = $urandom_range(0, 60) - 30;   end
                2: begin av[k] = LIM;  pv[k] = LIM;  end
                default: begin av[k] = -LIM; pv[k] = -LIM; end
            endcase
        end
    endtask

    task automatic run_block(input int code, input int first, input bit poke, input string tag);
        build_expect(code, first);
        @(negedge clk);
        code_sel = code[0]; first_iter = first[0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            begin : drv
                int k = 0;
                while (k < BLK) begin
                    bit gap;
                    bit take;
                    @(negedge clk);
                    gap = ($urandom_range(0, 3) == 0);
                    in_vld  = !gap;
                    in_apri = LLR_W'(av[k]);
                    in_chan = LLR_W'(pv[k]);
                    // R9: a start pulse with inverted mode while busy must be ignored.
                    if (poke && k == 5) begin
                        start = 1'b1; code_sel = ~code[0]; first_iter = ~first[0];
                    end else begin
                        start = 1'b0; code_sel = code[0]; first_iter = first[0];
                    end
                    take = in_rdy && !gap;
                    @(posedge clk);
                    if (take) k++;
                end
                @(negedge clk);
                in_vld = 1'b0; start = 1'b0;
            end
            begin : mon
                int got = 0;
                int dn = 0;
                while (got < BLK) begin
                    @(negedge clk);
                    if (in_rdy && out_vld) check("R2", "rdy with vld", 1, 0);
                    if (done) begin
                        dn++;
                        check("R9", "done position", got, BLK - 1);
                    end
                    if (out_vld) begin
                        check("R3", "out_idx", int'(out_idx), exp_idx[got]);
                        check(tag, "out_ext", int'(out_ext), exp_ext[got]);
                        got++;
                    end
                end
                check("R9", "done count", dn, 1);
                @(negedge clk);
                check("R2", "idle in_rdy", int'(in_rdy), 0);
                check("R2", "idle out_vld", int'(out_vld), 0);
            end
        join
    endtask

    // Watchdog: an expiry counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual=stalled expected=block completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int w = 0; w < N_WIN; w++) bnd_old[w] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "in_rdy after reset", int'(in_rdy), 0);
        check("R1", "out_vld after reset", int'(out_vld), 0);
        check("R1", "done after reset", int'(done), 0);

        fill(0); run_block(0, 1, 1'b0, "R5/R7");
        fill(0); run_block(0, 0, 1'b0, "R8");
        fill(1); run_block(0, 0, 1'b1, "R9");
        fill(2); run_block(0, 1, 1'b0, "R4");
        fill(3); run_block(0, 0, 1'b0, "R4");
        fill(0); run_block(1, 1, 1'b0, "R6");
        fill(1); run_block(1, 0, 1'b0, "R6/R8");
        fill(0); run_block(1, 0, 1'b1, "R6");
        fill(0); run_block(0, 1, 1'b0, "R8");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule